// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block picks which of three oscillators drives the system clock: the on-chip internal oscillator, an external crystal, or an external RC network. A requester names the wanted source. The block then walks the switch through a fixed safe order and raises a busy flag while it does so. The clock mux and the oscillators sit outside the block. The block drives a one-hot select into the mux, an enable into the crystal amplifier, and the output mode of the general-purpose pin that powers the RC network. That pin is either driven high as a push-pull output or left floating as an open-drain output.

Every change first parks the clock on the internal oscillator. On the way to the crystal, the RC supply pin is floated before the crystal is enabled, so the RC network cannot load the crystal circuit. The crystal then runs for a fixed startup wait, and the block waits further until the crystal reports a valid clock. On the way to the RC network, the crystal is stopped before the pin is driven, and there is no wait because the RC network starts almost at once. If the crystal never reports valid, the block stays on the internal oscillator and flags an error.

The startup wait is counted in internal-oscillator cycles. It is derived at build time from the internal frequency setting (2, 4, 8 or 16 MHz) and from a wait length in microseconds, which is 1 ms by default.

Top module: `clk_src_seq`

## Requirements
- R1: After reset, clk_sel is 3'b001 (bit 0 internal, bit 1 crystal, bit 2 RC), and xtal_en, rc_drive, busy and xtal_err are all 0.
- R2: req_src codes are 0 internal, 1 crystal and 2 RC. A request with code 3 is ignored, and so is a request for the source already in use. In both cases busy stays 0 and no output changes.
- R3: clk_sel is always one-hot. It never moves directly from one external source to the other; the internal oscillator is always selected in between.
- R4: On a switch to the crystal, clk_sel is 3'b001 and rc_drive is 0 at the moment xtal_en rises.
- R5: The crystal is selected only after xtal_en has been high for at least WAIT_CYC cycles, and only when xtal_valid was high in the cycle before the change.
- R6: If xtal_valid is not seen within TIMEOUT_CYC cycles after the wait ends, clk_sel stays 3'b001, xtal_en drops to 0 and xtal_err rises. xtal_err stays high until the next accepted request.
- R7: On a switch to RC, clk_sel is 3'b001 and xtal_en is 0 at the moment rc_drive rises. RC is selected no more than 6 cycles after the request, with no startup wait.
- R8: A request for the internal oscillator selects it and clears xtal_en, unless KEEP_XTAL is 1. rc_drive is left unchanged.
- R9: busy is 1 from the cycle after a request is accepted until the switch completes. A request made while busy is held. A later request replaces an earlier held one, and the held request runs after the current switch ends.
- R10: While the crystal is selected, xtal_en is 1 and rc_drive is 0. While RC is selected, xtal_en is 0 and rc_drive is 1.
- R11: WAIT_CYC equals (2 << INT_SEL) * WAIT_US, where INT_SEL values 0 to 3 mean 2, 4, 8 and 16 MHz. The crystal is selected no more than 4 cycles after this count when xtal_valid is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from the internal oscillator |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle pulse that requests a switch |
| req_src | input | 2 | Requested source code |
| xtal_valid | input | 1 | Crystal reports a stable clock |
| clk_sel | output | 3 | One-hot select into the clock mux |
| xtal_en | output | 1 | Crystal amplifier enable |
| rc_drive | output | 1 | 1: RC supply pin push-pull high; 0: open-drain, floating |
| busy | output | 1 | A switch is in progress |
| xtal_err | output | 1 | Last crystal switch timed out |

## Verification
The hardest case to reach is the held request: a second and a third request have to arrive while a crystal switch is still inside its startup wait, and the second must then be dropped. The stimulus starts a crystal switch whose model reports valid only late in the poll window. It then pulses an RC request followed by an internal request during the wait. The run has to finish on the crystal and then go straight to the internal oscillator. The timeout case uses a crystal model that never reports valid. A second crystal model reports valid well before the wait ends, which shows that the wait is still enforced.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_RC   = 2'd2
  } src_e;

  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_INT  = 3'b001;
  localparam logic [SEL_W-1:0] SEL_XTAL = 3'b010;
  localparam logic [SEL_W-1:0] SEL_RC   = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP1,
    ST_XEN,
    ST_WAIT,
    ST_POLL,
    ST_RCDRV,
    ST_RCSEL
  } seq_st_e;

endpackage

// File: rtl/clk_src_req_hold.sv
// Single-entry holding register for switch requests; newest request wins.
module clk_src_req_hold (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_src,
  input  logic       take,
  output logic       pend_valid,
  output logic [1:0] pend_src
);
  logic code_ok;
  assign code_ok = (req_src != 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_src   <= 2'd0;
    end else if (req_valid && code_ok) begin
      pend_valid <= 1'b1;
      pend_src   <= req_src;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_src_timer.sv
// Down counter shared by the startup wait and the valid-poll timeout.
module clk_src_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/clk_src_fsm.sv
// Switch sequencer: park on internal, set pin and crystal, wait, poll, commit.
module clk_src_fsm
  import clk_src_pkg::*;
#(
  parameter int unsigned TW          = 16,
  parameter int unsigned WAIT_CYC    = 16000,
  parameter int unsigned TIMEOUT_CYC = 4000,
  parameter bit          KEEP_XTAL   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_valid,
  input  logic [1:0]       pend_src,
  input  logic             xtal_valid,
  input  logic             tmr_expired,
  output logic             take,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic [SEL_W-1:0] clk_sel,
  output logic             xtal_en,
  output logic             rc_drive,
  output logic             busy,
  output logic             xtal_err
);
  seq_st_e state;
  src_e    cur;
  src_e    tgt;
  src_e    pend_e;

  assign pend_e   = src_e'(pend_src);
  assign take     = pend_valid && (state == ST_IDLE);
  assign tmr_load = (state == ST_XEN) || ((state == ST_WAIT) && tmr_expired);
  assign tmr_val  = (state == ST_XEN) ? TW'(WAIT_CYC) : TW'(TIMEOUT_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur      <= SRC_INT;
      tgt      <= SRC_INT;
      clk_sel  <= SEL_INT;
      xtal_en  <= 1'b0;
      rc_drive <= 1'b0;
      busy     <= 1'b0;
      xtal_err <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take && (pend_e != cur)) begin
            clk_sel  <= SEL_INT;
            busy     <= 1'b1;
            xtal_err <= 1'b0;
            tgt      <= pend_e;
            state    <= ST_STEP1;
          end
        end
        ST_STEP1: begin
          unique case (tgt)
            SRC_XTAL: begin
              rc_drive <= 1'b0;
              state    <= ST_XEN;
            end
            SRC_RC: begin
              xtal_en <= 1'b0;
              state   <= ST_RCDRV;
            end
            default: begin
              if (!KEEP_XTAL) xtal_en <= 1'b0;
              cur   <= SRC_INT;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          endcase
        end
        ST_XEN: begin
          xtal_en <= 1'b1;
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tmr_expired) state <= ST_POLL;
        end
        ST_POLL: begin
          if (xtal_valid) begin
            clk_sel <= SEL_XTAL;
            cur     <= SRC_XTAL;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end else if (tmr_expired) begin
            xtal_en  <= 1'b0;
            xtal_err <= 1'b1;
            cur      <= SRC_INT;
            busy     <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_RCDRV: begin
          rc_drive <= 1'b1;
          state    <= ST_RCSEL;
        end
        ST_RCSEL: begin
          clk_sel <= SEL_RC;
          cur     <= SRC_RC;
          busy    <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_src_seq.sv
// Top: request holder, sequencer and shared timer.
module clk_src_seq
  import clk_src_pkg::*;
#(
  parameter int unsigned INT_SEL     = 3,
  parameter int unsigned WAIT_US     = 1000,
  parameter int unsigned TIMEOUT_CYC = 4000,
  parameter bit          KEEP_XTAL   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_src,
  input  logic       xtal_valid,
  output logic [2:0] clk_sel,
  output logic       xtal_en,
  output logic       rc_drive,
  output logic       busy,
  output logic       xtal_err
);
  localparam int unsigned INT_MHZ  = 2 << (INT_SEL & 3);
  localparam int unsigned WAIT_CYC = INT_MHZ * WAIT_US;
  localparam int unsigned MAX_CYC  = (WAIT_CYC > TIMEOUT_CYC) ? WAIT_CYC : TIMEOUT_CYC;
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);

  logic          pend_valid;
  logic [1:0]    pend_src;
  logic          take;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;

  clk_src_req_hold hold_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_src    (req_src),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_src   (pend_src)
  );

  clk_src_timer #(.TW(TW)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  clk_src_fsm #(
    .TW          (TW),
    .WAIT_CYC    (WAIT_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .KEEP_XTAL   (KEEP_XTAL)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .pend_valid  (pend_valid),
    .pend_src    (pend_src),
    .xtal_valid  (xtal_valid),
    .tmr_expired (tmr_expired),
    .take        (take),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .clk_sel     (clk_sel),
    .xtal_en     (xtal_en),
    .rc_drive    (rc_drive),
    .busy        (busy),
    .xtal_err    (xtal_err)
  );
endmodule

// File: rtl/clk_src_seq_chk.sv
module clk_src_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] clk_sel,
  input logic       xtal_en,
  input logic       rc_drive,
  input logic       xtal_valid,
  input logic       xtal_err
);
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(clk_sel) == 1);

  assert_no_ext_to_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (clk_sel != 3'b001 && $past(clk_sel) != 3'b001) |-> clk_sel == $past(clk_sel));

  assert_xtal_after_pin_float_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(xtal_en) |-> (!rc_drive && clk_sel == 3'b001));

  assert_xtal_sel_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_sel[1]) |-> $past(xtal_valid));

  assert_err_on_internal_R6: assert property (@(posedge clk) disable iff (rst)
    xtal_err |-> (clk_sel == 3'b001 && !xtal_en));

  assert_rc_after_xtal_off_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rc_drive) |-> (!xtal_en && clk_sel == 3'b001));

  assert_xtal_pins_R10: assert property (@(posedge clk) disable iff (rst)
    clk_sel[1] |-> (xtal_en && !rc_drive));

  assert_rc_pins_R10: assert property (@(posedge clk) disable iff (rst)
    clk_sel[2] |-> (!xtal_en && rc_drive));
endmodule

bind clk_src_seq clk_src_seq_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .clk_sel    (clk_sel),
  .xtal_en    (xtal_en),
  .rc_drive   (rc_drive),
  .xtal_valid (xtal_valid),
  .xtal_err   (xtal_err)
);

// File: tb/clk_src_seq_tb_top.sv
module clk_src_seq_tb_top;
  localparam int WAIT = (2 << 0) * 10;  // INT_SEL=0 (2 MHz), WAIT_US=10 -> R11
  localparam int TMO  = 30;
  localparam int NVEC = 8;
  // vector: [1:0] src, [3:2] crystal model, [6:4] expected sel, [7] expected error
  localparam logic [7:0] VEC [0:NVEC-1] = '{
    {1'b0, 3'b010, 2'd1, 2'd1},
    {1'b0, 3'b100, 2'd0, 2'd2},
    {1'b0, 3'b010, 2'd2, 2'd1},
    {1'b0, 3'b001, 2'd0, 2'd0},
    {1'b1, 3'b001, 2'd0, 2'd1},
    {1'b0, 3'b100, 2'd0, 2'd2},
    {1'b0, 3'b010, 2'd1, 2'd1},
    {1'b0, 3'b001, 2'd0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_src = 2'd0;
  logic xtal_valid = 1'b0;
  logic [2:0] clk_sel;
  logic xtal_en, rc_drive, busy, xtal_err;

  int n_chk = 0;
  int n_fail = 0;
  int en_cnt = 0;
  int xmode = 0;
  int cyc = 0;
  logic prev_xen = 1'b0;
  logic prev_rc = 1'b0;
  logic [2:0] prev_sel = 3'b001;

  always #10 clk = ~clk;

  clk_src_seq #(.INT_SEL(0), .WAIT_US(10), .TIMEOUT_CYC(TMO), .KEEP_XTAL(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .xtal_valid(xtal_valid), .clk_sel(clk_sel), .xtal_en(xtal_en),
    .rc_drive(rc_drive), .busy(busy), .xtal_err(xtal_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // crystal model and ordering monitors
  always @(negedge clk) begin
    cyc++;
    en_cnt = xtal_en ? en_cnt + 1 : 0;
    xtal_valid = (xmode == 1 && en_cnt >= 3) || (xmode == 2 && en_cnt >= WAIT + 6);
    if (!rst) begin
      chk($countones(clk_sel) == 1, "R3 one-hot", clk_sel, 1);
      if (prev_sel != 3'b001 && clk_sel != 3'b001)
        chk(clk_sel == prev_sel, "R3 ext-to-ext", clk_sel, prev_sel);
      if (xtal_en && !prev_xen)
        chk(!rc_drive && clk_sel == 3'b001, "R4 order", {clk_sel, rc_drive}, 4'b0010);
      if (rc_drive && !prev_rc)
        chk(!xtal_en && clk_sel == 3'b001, "R7 order", {clk_sel, xtal_en}, 4'b0010);
    end
    prev_xen = xtal_en;
    prev_rc  = rc_drive;
    prev_sel = clk_sel;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic pulse(input logic [1:0] s);
    @(negedge clk);
    req_valid = 1'b1;
    req_src = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_req(input logic [1:0] s, output int lat);
    pulse(s);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (busy && lat < 500);
  endtask

  initial begin
    int lat;
    logic exp_rc;
    logic [2:0] sel_before;
    exp_rc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(clk_sel == 3'b001, "R1 clk_sel", clk_sel, 1);
    chk({xtal_en, rc_drive, busy, xtal_err} == 4'b0, "R1 flags",
        {xtal_en, rc_drive, busy, xtal_err}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] s;
      logic [2:0] es;
      s  = VEC[i][1:0];
      es = VEC[i][6:4];
      xmode = int'(VEC[i][3:2]);
      run_req(s, lat);
      if (s == 2'd1 && !VEC[i][7]) exp_rc = 1'b0;
      if (s == 2'd1 && VEC[i][7])  exp_rc = 1'b0;
      if (s == 2'd2) exp_rc = 1'b1;
      chk(clk_sel == es, "R2/R5/R7/R8 final sel", clk_sel, es);
      chk(xtal_err == VEC[i][7], "R6 error flag", xtal_err, VEC[i][7]);
      chk(xtal_en == (es == 3'b010), "R8/R10 xtal_en", xtal_en, es == 3'b010);
      chk(rc_drive == exp_rc, "R10 rc_drive", rc_drive, exp_rc);
      if (es == 3'b010)
        chk(en_cnt >= WAIT, "R5 startup wait", en_cnt, WAIT);
      if (es == 3'b010 && xmode == 1)
        chk(en_cnt <= WAIT + 4, "R11 wait length", en_cnt, WAIT + 4);
      if (s == 2'd2)
        chk(lat <= 6, "R7 no wait", lat, 6);
      if (VEC[i][7])
        chk(lat >= WAIT + TMO, "R6 timeout length", lat, WAIT + TMO);
    end

    // R2: invalid code ignored (now on internal)
    sel_before = clk_sel;
    run_req(2'd3, lat);
    chk(busy == 1'b0 && lat == 1, "R2 code 3 busy", lat, 1);
    chk(clk_sel == sel_before, "R2 code 3 sel", clk_sel, sel_before);
    // R2: same source ignored
    run_req(2'd0, lat);
    chk(lat == 1 && clk_sel == 3'b001, "R2 same source", lat, 1);

    // R9: held requests, newest wins
    xmode = 2;
    pulse(2'd1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R9 busy during switch", busy, 1);
    pulse(2'd2);
    pulse(2'd0);
    lat = 0;
    while (busy && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    chk(clk_sel == 3'b010, "R9 first switch done", clk_sel, 3'b010);
    repeat (10) @(negedge clk);
    chk(clk_sel == 3'b001, "R9 newest held runs", clk_sel, 3'b001);
    chk(xtal_en == 1'b0 && rc_drive == 1'b0, "R9 RC dropped / R8", {xtal_en, rc_drive}, 0);
    chk(busy == 1'b0, "R9 idle after", busy, 0);

    // R1: reset in the middle of a switch
    xmode = 0;
    pulse(2'd1);
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(clk_sel == 3'b001 && {xtal_en, rc_drive, busy, xtal_err} == 4'b0,
        "R1 mid-switch reset", {clk_sel, xtal_en, rc_drive, busy, xtal_err}, 7'b0010000);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule